// File: doc/BRIEF.md
# Eight-Channel PWM H-Bridge Driver

This block produces pulse width modulated drive for a bank of motor H-bridges. A single programmable prescaler divides the system clock into count ticks. One shared period counter steps through the full range of the duty width on those ticks. Each channel compares that count against its own duty value. A channel then drives its bridge in one of two modes. In sign/magnitude mode, a direction line selects polarity, and the pulse sets how much of the period the voltage is applied. In anti-phase mode, the two bridge legs are driven as exact complements every period, so mid-scale duty gives zero net voltage.

Software programs the block through a simple write port. Address 0 holds the prescale value. Each channel owns two neighbouring addresses: the lower one holds its duty value and the next one holds its control bits. Duty, mode and direction writes are held in a shadow copy and take effect only when the period counter wraps, so a period is never cut short by a write. The enable bit acts immediately.

Top module: `pwm_bridge_bank`

## Requirements
- R1: After reset, every output is low, the period count is zero, the prescale is zero and all channels are disabled.
- R2: The period counter advances by one every (prescale + 1) clocks, so one PWM period lasts (prescale + 1) × 2^DUTY_W clocks. The prescale value is compared with the tick counter using greater-or-equal, so lowering it takes effect at once.
- R3: While a channel is enabled, pwm_out is high exactly while the period count is below the active duty. Duty 0 is never high, and duty 255 is high for 255 of 256 counts.
- R4: Duty 128 gives a 50% square wave, which is (prescale + 1) × 128 high clocks per period.
- R5: Duty, mode and direction writes go to a shadow copy. The shadow copy is moved to the active copy only on the clock at which the period count wraps from 255 to 0. A write on that same clock waits for the following wrap.
- R6: The enable bit acts on the clock after its write. While a channel is disabled, its pwm_out, dir_out, hb_pos and hb_neg are all low.
- R7: In sign/magnitude mode (mode bit 0), dir_out equals the active direction, hb_pos = pwm_out AND NOT dir, and hb_neg = pwm_out AND dir.
- R8: In anti-phase mode (mode bit 1), hb_pos equals pwm_out, hb_neg is its exact complement, and dir_out is low.
- R9: The write map is as follows. Address 0 is the prescale. Address 1+2c is the duty of channel c, taken from data bits [7:0]. Address 2+2c is the control of channel c: bit 0 is enable, bit 1 is mode, bit 2 is direction. Writes to any higher address change nothing.
- R10: Channels are independent. A write to one channel changes no other channel's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 16 | Register write data |
| pwm_out | output | 8 | Per-channel modulated pulse |
| dir_out | output | 8 | Per-channel direction (sign/magnitude mode only) |
| hb_pos | output | 8 | Per-channel positive bridge leg drive |
| hb_neg | output | 8 | Per-channel negative bridge leg drive |

## Verification
The bench builds the block with its defaults: eight channels, an 8-bit duty and a 16-bit prescale, with outputs left unregistered. Random prescale writes are kept within 0 to 3, so a period lasts 256 to 1024 clocks. This lets a run pass through many counter wraps, many shadow-to-active transfers and many mode and direction changes within its cycle budget. A write landing on the exact wrap clock therefore occurs repeatedly. Writes to addresses above the map exercise the ignore path. Directed windows one period long measure the high time at duty 0, 128 and 255.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

   typedef enum logic {
      MODE_SIGN_MAG  = 1'b0,
      MODE_ANTIPHASE = 1'b1
   } drive_mode_e;

   // control word bit positions (decoded by each channel)
   localparam int CTL_EN_BIT   = 0;
   localparam int CTL_MODE_BIT = 1;
   localparam int CTL_DIR_BIT  = 2;
   localparam int CTL_W        = 3;

   typedef struct packed {
      logic pwm;
      logic dir;
      logic pos;
      logic neg;
   } bridge_drive_t;

   function automatic bridge_drive_t form_drive(input logic enabled,
                                                input logic on,
                                                input drive_mode_e mode,
                                                input logic dir);
      bridge_drive_t d;
      d = '0;
      if (enabled) begin
         d.pwm = on;
         if (mode == MODE_ANTIPHASE) begin
            d.pos = on;
            d.neg = ~on;
            d.dir = 1'b0;
         end else begin
            d.dir = dir;
            d.pos = on & ~dir;
            d.neg = on & dir;
         end
      end
      return d;
   endfunction

endpackage

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen #(
   parameter int PRE_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PRE_W-1:0] prescale,
   output logic             tick
);
   logic [PRE_W-1:0] div_q;

   assign tick = (div_q >= prescale);

   always_ff @(posedge clk) begin
      if (!rst_n) div_q <= '0;
      else if (tick) div_q <= '0;
      else div_q <= div_q + PRE_W'(1);
   end

   // R2: divider never runs past the programmed limit by more than a write
   a_r2_div_resets: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> (div_q == '0));
endmodule

// File: rtl/pwm_period_ctr.sv
module pwm_period_ctr #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   output logic [CNT_W-1:0] count,
   output logic             wrap
);
   localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

   assign wrap = tick && (count == CNT_TOP);

   always_ff @(posedge clk) begin
      if (!rst_n) count <= '0;
      else if (tick) count <= count + CNT_W'(1);
   end

   a_r2_step_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> (count == $past(count) + CNT_W'(1)));
   a_r2_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(count));
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
   import pwm_bank_pkg::*;
#(
   parameter int DUTY_W  = 8,
   parameter bit OUT_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              duty_we,
   input  logic [DUTY_W-1:0] duty_wd,
   input  logic              ctl_we,
   input  logic [CTL_W-1:0]  ctl_wd,
   input  logic [DUTY_W-1:0] count,
   input  logic              wrap,
   output logic              pwm_o,
   output logic              dir_o,
   output logic              pos_o,
   output logic              neg_o
);
   logic [DUTY_W-1:0] shd_duty, act_duty;
   drive_mode_e       shd_mode, act_mode;
   logic              shd_dir, act_dir;
   logic              en_q;
   logic              on_c;
   bridge_drive_t     drv_c;

   // shadow copy: updated by writes
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shd_duty <= '0;
         shd_mode <= MODE_SIGN_MAG;
         shd_dir  <= 1'b0;
         en_q     <= 1'b0;
      end else begin
         if (duty_we) shd_duty <= duty_wd;
         if (ctl_we) begin
            en_q     <= ctl_wd[CTL_EN_BIT];
            shd_mode <= drive_mode_e'(ctl_wd[CTL_MODE_BIT]);
            shd_dir  <= ctl_wd[CTL_DIR_BIT];
         end
      end
   end

   // active copy: loaded only at the period wrap
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_duty <= '0;
         act_mode <= MODE_SIGN_MAG;
         act_dir  <= 1'b0;
      end else if (wrap) begin
         act_duty <= shd_duty;
         act_mode <= shd_mode;
         act_dir  <= shd_dir;
      end
   end

   assign on_c  = (count < act_duty);
   assign drv_c = form_drive(en_q, on_c, act_mode, act_dir);

   generate
      if (OUT_REG) begin : g_reg_out
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               pwm_o <= 1'b0; dir_o <= 1'b0; pos_o <= 1'b0; neg_o <= 1'b0;
            end else begin
               pwm_o <= drv_c.pwm; dir_o <= drv_c.dir;
               pos_o <= drv_c.pos; neg_o <= drv_c.neg;
            end
         end
      end else begin : g_comb_out
         assign pwm_o = drv_c.pwm;
         assign dir_o = drv_c.dir;
         assign pos_o = drv_c.pos;
         assign neg_o = drv_c.neg;
      end
   endgenerate

   a_r5_duty_held: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wrap) |-> $stable(act_duty));
   a_r3_zero_duty_off: assert property (@(posedge clk) disable iff (!rst_n)
      (act_duty == '0) |-> !drv_c.pwm);
   a_r6_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |-> (drv_c == '0));
   a_r8_complement: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && act_mode == MODE_ANTIPHASE) |-> (drv_c.pos ^ drv_c.neg));
   a_r7_legs_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      (act_mode == MODE_SIGN_MAG) |-> !(drv_c.pos && drv_c.neg));
endmodule

// File: rtl/pwm_bridge_bank.sv
module pwm_bridge_bank
   import pwm_bank_pkg::*;
#(
   parameter int NUM_CH  = 8,
   parameter int DUTY_W  = 8,
   parameter int PRE_W   = 16,
   parameter bit OUT_REG = 1'b0,
   localparam int DATA_W = PRE_W,
   localparam int ADDR_W = $clog2(2*NUM_CH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [NUM_CH-1:0] pwm_out,
   output logic [NUM_CH-1:0] dir_out,
   output logic [NUM_CH-1:0] hb_pos,
   output logic [NUM_CH-1:0] hb_neg
);
   generate
      if (NUM_CH < 1) begin : g_bad_ch
         $error("NUM_CH must be at least 1");
      end
      if (DUTY_W < 2) begin : g_bad_duty
         $error("DUTY_W must be at least 2");
      end
      if (DATA_W < DUTY_W || DATA_W < CTL_W) begin : g_bad_data
         $error("PRE_W too narrow for duty or control writes");
      end
   endgenerate

   logic [PRE_W-1:0]  prescale_q;
   logic              tick;
   logic [DUTY_W-1:0] count;
   logic              wrap;

   always_ff @(posedge clk) begin
      if (!rst_n) prescale_q <= '0;
      else if (wr_en && wr_addr == '0) prescale_q <= wr_data;
   end

   pwm_tick_gen #(.PRE_W(PRE_W)) u_tick (
      .clk(clk), .rst_n(rst_n), .prescale(prescale_q), .tick(tick)
   );

   pwm_period_ctr #(.CNT_W(DUTY_W)) u_ctr (
      .clk(clk), .rst_n(rst_n), .tick(tick), .count(count), .wrap(wrap)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      localparam logic [ADDR_W-1:0] DUTY_ADDR = ADDR_W'(1 + 2*c);
      localparam logic [ADDR_W-1:0] CTL_ADDR  = ADDR_W'(2 + 2*c);
      logic duty_we, ctl_we;
      assign duty_we = wr_en && (wr_addr == DUTY_ADDR);
      assign ctl_we  = wr_en && (wr_addr == CTL_ADDR);

      pwm_channel #(.DUTY_W(DUTY_W), .OUT_REG(OUT_REG)) u_ch (
         .clk(clk), .rst_n(rst_n),
         .duty_we(duty_we), .duty_wd(wr_data[DUTY_W-1:0]),
         .ctl_we(ctl_we), .ctl_wd(wr_data[CTL_W-1:0]),
         .count(count), .wrap(wrap),
         .pwm_o(pwm_out[c]), .dir_o(dir_out[c]),
         .pos_o(hb_pos[c]), .neg_o(hb_neg[c])
      );
   end

   a_r1_idle_after_reset: assert property (@(posedge clk)
      $rose(rst_n) |-> (pwm_out == '0 && hb_pos == '0 && hb_neg == '0 && dir_out == '0));
   a_r2_prescale_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == '0) |=> (prescale_q == $past(wr_data)));
endmodule

// File: tb/tb_pwm_bridge_bank.sv
module tb_pwm_bridge_bank;
   localparam int CLK_PERIOD = 10;
   localparam int NCH = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [4:0] wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [NCH-1:0] pwm_out, dir_out, hb_pos, hb_neg;

   int total = 0;
   int bad = 0;
   bit checking = 1'b0;

   pwm_bridge_bank dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .pwm_out(pwm_out), .dir_out(dir_out),
      .hb_pos(hb_pos), .hb_neg(hb_neg)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // reference model built from the requirements
   int   m_div, m_pre, m_cnt;
   int   m_sd[NCH], m_ad[NCH];
   bit   m_sm[NCH], m_am[NCH], m_sr[NCH], m_ar[NCH], m_en[NCH];

   always @(posedge clk) begin
      if (!rst_n) begin
         m_div = 0; m_pre = 0; m_cnt = 0;
         for (int c = 0; c < NCH; c++) begin
            m_sd[c] = 0; m_ad[c] = 0; m_sm[c] = 0; m_am[c] = 0;
            m_sr[c] = 0; m_ar[c] = 0; m_en[c] = 0;
         end
      end else begin
         bit tk, wp;
         tk = (m_div >= m_pre);
         wp = tk && (m_cnt == 255);
         m_div = tk ? 0 : m_div + 1;
         if (tk) m_cnt = (m_cnt + 1) % 256;
         if (wp)
            for (int c = 0; c < NCH; c++) begin
               m_ad[c] = m_sd[c]; m_am[c] = m_sm[c]; m_ar[c] = m_sr[c];
            end
         if (wr_en) begin
            if (wr_addr == 0) m_pre = int'(wr_data);
            else if (wr_addr <= 2*NCH) begin
               int ch;
               ch = (int'(wr_addr) - 1) / 2;
               if (wr_addr[0]) m_sd[ch] = int'(wr_data[7:0]);
               else begin
                  m_en[ch] = wr_data[0]; m_sm[ch] = wr_data[1]; m_sr[ch] = wr_data[2];
               end
            end
         end
      end
   end

   function automatic logic [3:0] exp_drive(input int c);
      logic on;
      on = m_en[c] && (m_cnt < m_ad[c]);
      if (!m_en[c]) return 4'b0000;
      if (m_am[c]) return {on, 1'b0, on, ~on};
      return {on, m_ar[c], on & ~m_ar[c], on & m_ar[c]};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && checking) begin
         logic [NCH-1:0] ep, ed, epos, eneg;
         for (int c = 0; c < NCH; c++) begin
            logic [3:0] e;
            e = exp_drive(c);
            ep[c] = e[3]; ed[c] = e[2]; epos[c] = e[1]; eneg[c] = e[0];
         end
         check("R3 pwm_out", 32'(pwm_out), 32'(ep));
         check("R7 dir_out", 32'(dir_out), 32'(ed));
         check("R7 R8 hb_pos", 32'(hb_pos), 32'(epos));
         check("R8 R10 hb_neg", 32'(hb_neg), 32'(eneg));
      end
   end

   task automatic wr(input int a, input int d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 5'(a); wr_data = 16'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // count high clocks of pwm_out[ch] over one full period
   task automatic measure(input int ch, input int pre, input int exp, input string req);
      int hi;
      hi = 0;
      for (int i = 0; i < (pre + 1) * 256; i++) begin
         @(negedge clk);
         if (pwm_out[ch]) hi++;
      end
      check(req, 32'(hi), 32'(exp));
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 outputs idle", 32'({pwm_out, dir_out, hb_pos, hb_neg}), 32'h0);
      checking = 1'b1;

      // R2 R4 directed period measurements on channel 0
      wr(0, 2);
      wr(1, 128);
      wr(2, 1);
      repeat (2 * 768) @(negedge clk);
      measure(0, 2, 384, "R4 R2 duty128 high time");
      wr(1, 255);
      repeat (2 * 768) @(negedge clk);
      measure(0, 2, 765, "R3 duty255 high time");
      wr(1, 0);
      repeat (2 * 768) @(negedge clk);
      measure(0, 2, 0, "R3 duty0 high time");

      // R6 disable takes hold on the next clock
      wr(1, 200);
      wr(2, 3);
      repeat (2 * 768) @(negedge clk);
      wr(2, 0);
      check("R6 disabled low", 32'({pwm_out[0], hb_pos[0], hb_neg[0]}), 32'h0);

      // R9 out-of-map writes ignored (model agrees, compared each cycle)
      wr(20, 16'hffff);
      wr(31, 16'h0007);

      // random stimulus
      for (int i = 0; i < 3000; i++) begin
         int kind, ch;
         kind = int'($urandom_range(0, 9));
         ch = int'($urandom_range(0, NCH - 1));
         case (kind)
            0: wr(0, int'($urandom_range(0, 3)));
            1, 2, 3: wr(1 + 2*ch, int'($urandom_range(0, 255)));
            4, 5: wr(2 + 2*ch, int'($urandom_range(0, 7)));
            6: wr(int'($urandom_range(17, 31)), int'($urandom));
            default: repeat (int'($urandom_range(1, 60))) @(negedge clk);
         endcase
      end
      // R5 write at every cycle near the wrap for channel 7 duty
      wr(0, 0);
      for (int i = 0; i < 300; i++) wr(15, i % 256);
      repeat (600) @(negedge clk);

      checking = 1'b0;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule